// File: doc/BRIEF.md
# Age-Ordered Per-Instruction Request Buffer

This block sits in front of a memory coalescer and holds per-lane memory requests that have not yet been merged. Requests arrive one lane at a time, each tagged with the sequence number of the instruction that issued it. All requests that share a sequence number are kept together in one column, which has one slot per lane of a wavefront. The buffer holds `NUM_COLS` columns, so it can store `NUM_COLS * LANES` requests in total.

In every cycle the block offers the coalescer up to `WINDOW` instruction groups, oldest first, each with its lane mask and lane data. The coalescer returns a per-slot removal mask. A column is released as soon as its last lane is removed. A combinational query reports whether any request of a given sequence number is still held. A watchdog compares each column's opening time with a free-running cycle counter and raises a sticky stall flag when a group stays longer than `STALL_LIMIT` cycles.

Top module: `instr_req_buffer`

## Requirements
- R1: After reset, `in_ready` is 1, `win_valid` is all zero, `stall` is 0, and `q_done` is 1 for any `q_seq`.
- R2: Accepted requests with the same sequence number share one group. The group's window slot shows a lane mask with bit L set for each held lane L, and the lane's data at bits `[(slot*LANES+L)*DATA_W +: DATA_W]` of `win_data`.
- R3: A request with a sequence number that is not held opens a group in a free column. When all columns are in use, such a request sees `in_ready` low and is not stored. A request that joins an existing group with an empty lane is still accepted.
- R4: A request for a lane that its group already holds sees `in_ready` low and leaves the group's mask and data unchanged.
- R5: Slot 0 carries the oldest group, and slot w carries the w-th oldest. Sequence number a counts as older than b when bit `SEQ_W-1` of `(a-b) mod 2^SEQ_W` is set. Valid slots are contiguous from slot 0, and at most `WINDOW` slots are valid.
- R6: A bit set in `rm_mask` for a valid slot clears that lane of the group at the next clock edge. Bits given for invalid slots have no effect.
- R7: A group is released when its last lane is removed. Its column then accepts a new sequence number.
- R8: `q_done` is 1 exactly when no request with sequence number `q_seq` is held.
- R9: `stall` rises when a group is still held `STALL_LIMIT` cycles after it was opened. It then stays high until reset. A group removed before that time never raises it.
- R10: The stall timer of a group counts from the cycle the group was opened. Lanes that join later do not restart it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An incoming lane request is present |
| in_ready | output | 1 | The incoming request can be stored this cycle |
| in_seq | input | SEQ_W | Sequence number of the issuing instruction |
| in_lane | input | LANE_W | Lane index of the request |
| in_data | input | DATA_W | Request payload |
| win_valid | output | WINDOW | Window slot holds a group |
| win_seq | output | WINDOW*SEQ_W | Sequence number per slot |
| win_mask | output | WINDOW*LANES | Held lanes per slot |
| win_data | output | WINDOW*LANES*DATA_W | Lane payloads per slot |
| rm_mask | input | WINDOW*LANES | Lanes to remove per slot |
| q_seq | input | SEQ_W | Sequence number being queried |
| q_done | output | 1 | No request of `q_seq` remains |
| stall | output | 1 | Sticky watchdog flag |

## Verification
The assertions check on every cycle the properties that hold at any moment:
- refusal when the buffer is full and acceptance when a column is free;
- the thermometer shape of the window and the age order between adjacent slots;
- non-empty masks in valid slots;
- `q_done` when the buffer is empty;
- that `stall` never falls once it has risen.

Only the bench's scenarios can show that data lands in the right lane and that removal takes effect one edge later. They also show that a column is reused after release, that age order holds across sequence-number wrap, and that the watchdog fires in the right cycle measured from the group's opening rather than from a later join.

// File: rtl/rqb_pkg.sv
package rqb_pkg;
    // What an incoming request does to one column in the current cycle.
    typedef enum logic [1:0] {
        INS_NONE = 2'd0,
        INS_JOIN = 2'd1,
        INS_OPEN = 2'd2
    } ins_kind_e;
endpackage

// File: rtl/rqb_column.sv
module rqb_column
    import rqb_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int LANE_W = 2,
    parameter int SEQ_W  = 8,
    parameter int DATA_W = 16,
    parameter int TS_W   = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  ins_kind_e                ins_kind,
    input  logic [SEQ_W-1:0]         ins_seq,
    input  logic [LANE_W-1:0]        ins_lane,
    input  logic [DATA_W-1:0]        ins_data,
    input  logic [TS_W-1:0]          ins_stamp,
    input  logic [LANES-1:0]         rm_lanes,
    output logic                     col_valid,
    output logic [SEQ_W-1:0]         col_seq,
    output logic [LANES-1:0]         col_mask,
    output logic [LANES*DATA_W-1:0]  col_data,
    output logic [TS_W-1:0]          col_stamp
);
    typedef struct packed {
        logic                              valid;
        logic [SEQ_W-1:0]                  seq;
        logic [LANES-1:0]                  mask;
        logic [LANES-1:0][DATA_W-1:0]      data;
        logic [TS_W-1:0]                   stamp;
    } col_t;

    col_t col_d, col_q;

    always_comb begin
        col_d      = col_q;
        col_d.mask = col_q.mask & ~rm_lanes;
        case (ins_kind)
            INS_JOIN: begin
                col_d.mask[ins_lane] = 1'b1;
                col_d.data[ins_lane] = ins_data;
            end
            INS_OPEN: begin
                col_d.valid          = 1'b1;
                col_d.seq            = ins_seq;
                col_d.stamp          = ins_stamp;
                col_d.mask           = '0;
                col_d.mask[ins_lane] = 1'b1;
                col_d.data[ins_lane] = ins_data;
            end
            default: ;
        endcase
        col_d.valid = col_d.valid && (|col_d.mask);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) col_q <= '0;
        else        col_q <= col_d;
    end

    assign col_valid = col_q.valid;
    assign col_seq   = col_q.seq;
    assign col_mask  = col_q.mask;
    assign col_data  = col_q.data;
    assign col_stamp = col_q.stamp;
endmodule

// File: rtl/rqb_oldest_pick.sv
module rqb_oldest_pick #(
    parameter int NUM_COLS = 4,
    parameter int WINDOW   = 2,
    parameter int SEQ_W    = 8,
    parameter int IDX_W    = 2
) (
    input  logic [NUM_COLS-1:0] col_valid,
    input  logic [SEQ_W-1:0]    col_seq [NUM_COLS],
    output logic [WINDOW-1:0]   pick_valid,
    output logic [IDX_W-1:0]    pick_idx [WINDOW]
);
    function automatic logic seq_older(input logic [SEQ_W-1:0] a, input logic [SEQ_W-1:0] b);
        logic [SEQ_W-1:0] diff;
        diff = a - b;
        return diff[SEQ_W-1];
    endfunction

    logic [NUM_COLS-1:0] taken;
    logic                found;
    logic [IDX_W-1:0]    best;

    // One pass per window slot; each pass takes the oldest column not yet taken.
    always_comb begin
        taken = '0;
        found = 1'b0;
        best  = '0;
        for (int w = 0; w < WINDOW; w++) begin
            found = 1'b0;
            best  = '0;
            for (int c = 0; c < NUM_COLS; c++) begin
                if (col_valid[c] && !taken[c] &&
                    (!found || seq_older(col_seq[c], col_seq[best]))) begin
                    found = 1'b1;
                    best  = IDX_W'(c);
                end
            end
            pick_valid[w] = found;
            pick_idx[w]   = best;
            if (found) taken[best] = 1'b1;
        end
    end
endmodule

// File: rtl/rqb_watchdog.sv
module rqb_watchdog #(
    parameter int NUM_COLS    = 4,
    parameter int TS_W        = 8,
    parameter int STALL_LIMIT = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_COLS-1:0] col_valid,
    input  logic [TS_W-1:0]     col_stamp [NUM_COLS],
    output logic [TS_W-1:0]     now,
    output logic                stall
);
    typedef struct packed {
        logic [TS_W-1:0] cyc;
        logic            stall;
    } wd_t;

    wd_t wd_d, wd_q;
    logic [TS_W-1:0] age;

    always_comb begin
        wd_d     = wd_q;
        wd_d.cyc = wd_q.cyc + 1'b1;
        age      = '0;
        for (int c = 0; c < NUM_COLS; c++) begin
            age = wd_q.cyc - col_stamp[c];
            if (col_valid[c] && (age >= TS_W'(STALL_LIMIT))) wd_d.stall = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) wd_q <= '0;
        else        wd_q <= wd_d;
    end

    assign now   = wd_q.cyc;
    assign stall = wd_q.stall;
endmodule

// File: rtl/instr_req_buffer.sv
module instr_req_buffer
    import rqb_pkg::*;
#(
    parameter int NUM_COLS    = 4,
    parameter int LANES       = 4,
    parameter int WINDOW      = 2,
    parameter int SEQ_W       = 8,
    parameter int DATA_W      = 16,
    parameter int STALL_LIMIT = 64,
    localparam int LANE_W     = $clog2(LANES),
    localparam int IDX_W      = $clog2(NUM_COLS),
    localparam int TS_W       = $clog2(STALL_LIMIT + 1) + 1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            in_valid,
    output logic                            in_ready,
    input  logic [SEQ_W-1:0]                in_seq,
    input  logic [LANE_W-1:0]               in_lane,
    input  logic [DATA_W-1:0]               in_data,
    output logic [WINDOW-1:0]               win_valid,
    output logic [WINDOW*SEQ_W-1:0]         win_seq,
    output logic [WINDOW*LANES-1:0]         win_mask,
    output logic [WINDOW*LANES*DATA_W-1:0]  win_data,
    input  logic [WINDOW*LANES-1:0]         rm_mask,
    input  logic [SEQ_W-1:0]                q_seq,
    output logic                            q_done,
    output logic                            stall
);
    logic [NUM_COLS-1:0]       col_valid;
    logic [SEQ_W-1:0]          col_seq   [NUM_COLS];
    logic [LANES-1:0]          col_mask  [NUM_COLS];
    logic [LANES*DATA_W-1:0]   col_data  [NUM_COLS];
    logic [TS_W-1:0]           col_stamp [NUM_COLS];
    logic [LANES-1:0]          col_rm    [NUM_COLS];
    ins_kind_e                 col_kind  [NUM_COLS];

    logic [WINDOW-1:0]         pick_valid;
    logic [IDX_W-1:0]          pick_idx [WINDOW];
    logic [TS_W-1:0]           now;

    logic                      any_hit, any_free, lane_busy, fire;
    logic [IDX_W-1:0]          hit_idx, free_idx;

    // Group lookup and lowest free column
    always_comb begin
        any_hit  = 1'b0;
        hit_idx  = '0;
        any_free = 1'b0;
        free_idx = '0;
        for (int c = NUM_COLS - 1; c >= 0; c--) begin
            if (col_valid[c] && col_seq[c] == in_seq) begin
                any_hit = 1'b1;
                hit_idx = IDX_W'(c);
            end
            if (!col_valid[c]) begin
                any_free = 1'b1;
                free_idx = IDX_W'(c);
            end
        end
        lane_busy = col_mask[hit_idx][in_lane];
        in_ready  = any_hit ? !lane_busy : any_free;
        fire      = in_valid && in_ready;
        for (int c = 0; c < NUM_COLS; c++) begin
            col_kind[c] = INS_NONE;
            if (fire && any_hit && hit_idx == IDX_W'(c))        col_kind[c] = INS_JOIN;
            else if (fire && !any_hit && free_idx == IDX_W'(c)) col_kind[c] = INS_OPEN;
        end
    end

    // Route window removal masks back to columns; invalid slots drop their bits
    always_comb begin
        for (int c = 0; c < NUM_COLS; c++) begin
            col_rm[c] = '0;
            for (int w = 0; w < WINDOW; w++) begin
                if (pick_valid[w] && pick_idx[w] == IDX_W'(c))
                    col_rm[c] = col_rm[c] | rm_mask[w*LANES +: LANES];
            end
        end
    end

    always_comb begin
        q_done = 1'b1;
        for (int c = 0; c < NUM_COLS; c++) begin
            if (col_valid[c] && col_seq[c] == q_seq) q_done = 1'b0;
        end
    end

    for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
        rqb_column #(
            .LANES(LANES), .LANE_W(LANE_W), .SEQ_W(SEQ_W),
            .DATA_W(DATA_W), .TS_W(TS_W)
        ) col_i (
            .clk(clk), .rst_n(rst_n),
            .ins_kind(col_kind[c]), .ins_seq(in_seq), .ins_lane(in_lane),
            .ins_data(in_data), .ins_stamp(now), .rm_lanes(col_rm[c]),
            .col_valid(col_valid[c]), .col_seq(col_seq[c]), .col_mask(col_mask[c]),
            .col_data(col_data[c]), .col_stamp(col_stamp[c])
        );
    end

    rqb_oldest_pick #(
        .NUM_COLS(NUM_COLS), .WINDOW(WINDOW), .SEQ_W(SEQ_W), .IDX_W(IDX_W)
    ) pick_i (
        .col_valid(col_valid), .col_seq(col_seq),
        .pick_valid(pick_valid), .pick_idx(pick_idx)
    );

    rqb_watchdog #(
        .NUM_COLS(NUM_COLS), .TS_W(TS_W), .STALL_LIMIT(STALL_LIMIT)
    ) wd_i (
        .clk(clk), .rst_n(rst_n), .col_valid(col_valid),
        .col_stamp(col_stamp), .now(now), .stall(stall)
    );

    for (genvar w = 0; w < WINDOW; w++) begin : g_win
        assign win_valid[w]                              = pick_valid[w];
        assign win_seq[w*SEQ_W +: SEQ_W]                 = pick_valid[w] ? col_seq[pick_idx[w]] : '0;
        assign win_mask[w*LANES +: LANES]                = pick_valid[w] ? col_mask[pick_idx[w]] : '0;
        assign win_data[w*LANES*DATA_W +: LANES*DATA_W]  = pick_valid[w] ? col_data[pick_idx[w]] : '0;
    end
endmodule

// File: rtl/rqb_checker.sv
module rqb_checker #(
    parameter int NUM_COLS = 4,
    parameter int LANES    = 4,
    parameter int WINDOW   = 2,
    parameter int SEQ_W    = 8
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      in_ready,
    input logic                      any_hit,
    input logic [NUM_COLS-1:0]       col_valid,
    input logic [WINDOW-1:0]         win_valid,
    input logic [WINDOW*SEQ_W-1:0]   win_seq,
    input logic [WINDOW*LANES-1:0]   win_mask,
    input logic                      q_done,
    input logic                      stall
);
    p_full_refuse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((&col_valid) && !any_hit) |-> !in_ready);

    p_free_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!(&col_valid) && !any_hit) |-> in_ready);

    p_win_contig_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((win_valid & (win_valid + 1'b1)) == '0));

    p_empty_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid == '0) |-> q_done);

    p_stall_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> stall);

    for (genvar w = 0; w < WINDOW; w++) begin : g_slot
        p_slot_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
            win_valid[w] |-> (|win_mask[w*LANES +: LANES]));
        if (w > 0) begin : g_ord
            logic [SEQ_W-1:0] gap;
            assign gap = win_seq[(w-1)*SEQ_W +: SEQ_W] - win_seq[w*SEQ_W +: SEQ_W];
            p_age_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
                win_valid[w] |-> gap[SEQ_W-1]);
        end
    end
endmodule

bind instr_req_buffer rqb_checker #(
    .NUM_COLS(NUM_COLS), .LANES(LANES), .WINDOW(WINDOW), .SEQ_W(SEQ_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .any_hit(any_hit),
    .col_valid(col_valid), .win_valid(win_valid), .win_seq(win_seq),
    .win_mask(win_mask), .q_done(q_done), .stall(stall)
);

// File: tb/instr_req_buffer_tb_top.sv
module instr_req_buffer_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NC = 4, LN = 4, WN = 2, SW = 4, DW = 8, LIM = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [SW-1:0] in_seq = '0;
    logic [1:0] in_lane = '0;
    logic [DW-1:0] in_data = '0;
    logic [WN-1:0] win_valid;
    logic [WN*SW-1:0] win_seq;
    logic [WN*LN-1:0] win_mask;
    logic [WN*LN*DW-1:0] win_data;
    logic [WN*LN-1:0] rm_mask = '0;
    logic [SW-1:0] q_seq = '0;
    logic q_done, stall;

    int checks = 0, errors = 0, cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    instr_req_buffer #(
        .NUM_COLS(NC), .LANES(LN), .WINDOW(WN), .SEQ_W(SW),
        .DATA_W(DW), .STALL_LIMIT(LIM)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_seq(in_seq), .in_lane(in_lane), .in_data(in_data),
        .win_valid(win_valid), .win_seq(win_seq), .win_mask(win_mask),
        .win_data(win_data), .rm_mask(rm_mask), .q_seq(q_seq),
        .q_done(q_done), .stall(stall)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            errors++;
            $display("FAIL watchdog: act=%0d exp<100000 cycles", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic push(input int s, input int l, input int d, input logic exp_rdy, input string req);
        in_valid = 1'b1;
        in_seq   = SW'(s);
        in_lane  = 2'(l);
        in_data  = DW'(d);
        #1;
        chk(req, 64'(in_ready), 64'(exp_rdy));
        tick();
        in_valid = 1'b0;
    endtask

    function automatic logic [SW-1:0] sseq(input int w);
        return win_seq[w*SW +: SW];
    endfunction

    function automatic logic [LN-1:0] smask(input int w);
        return win_mask[w*LN +: LN];
    endfunction

    function automatic logic [DW-1:0] sdata(input int w, input int l);
        return win_data[(w*LN + l)*DW +: DW];
    endfunction

    task automatic query(input int s, input logic exp, input string req);
        q_seq = SW'(s);
        #1;
        chk(req, 64'(q_done), 64'(exp));
    endtask

    task automatic drain;
        for (int i = 0; i < 20; i++) begin
            if (win_valid == '0) break;
            for (int w = 0; w < WN; w++)
                rm_mask[w*LN +: LN] = win_valid[w] ? smask(w) : '0;
            tick();
        end
        rm_mask = '0;
    endtask

    task automatic do_reset;
        rst_n = 1'b0;
        tick();
        tick();
        rst_n = 1'b1;
        #1;
    endtask

    initial begin
        do_reset();
        // R1 reset state
        chk("R1 ready", 64'(in_ready), 64'd1);
        chk("R1 win_valid", 64'(win_valid), 64'd0);
        chk("R1 stall", 64'(stall), 64'd0);
        for (int s = 0; s < 16; s++) query(s, 1'b1, "R1 q_done");

        // R2 grouping and lane data, R5 order
        push(5, 0, 8'h50, 1'b1, "R2 open");
        push(5, 2, 8'h52, 1'b1, "R2 join");
        push(6, 1, 8'h61, 1'b1, "R3 open second");
        chk("R5 valid", 64'(win_valid), 64'b11);
        chk("R5 slot0 seq", 64'(sseq(0)), 64'd5);
        chk("R5 slot1 seq", 64'(sseq(1)), 64'd6);
        chk("R2 slot0 mask", 64'(smask(0)), 64'b0101);
        chk("R2 lane0 data", 64'(sdata(0, 0)), 64'h50);
        chk("R2 lane2 data", 64'(sdata(0, 2)), 64'h52);
        chk("R2 slot1 mask", 64'(smask(1)), 64'b0010);
        chk("R2 slot1 data", 64'(sdata(1, 1)), 64'h61);
        query(5, 1'b0, "R8 held");
        query(7, 1'b1, "R8 absent");

        // R4 occupied lane refused, group unchanged
        push(5, 0, 8'hEE, 1'b0, "R4 refuse");
        chk("R4 mask kept", 64'(smask(0)), 64'b0101);
        chk("R4 data kept", 64'(sdata(0, 0)), 64'h50);

        // R3 full buffer
        push(7, 0, 8'h70, 1'b1, "R3 third");
        push(8, 0, 8'h80, 1'b1, "R3 fourth");
        push(9, 0, 8'h90, 1'b0, "R3 full refuse");
        query(9, 1'b1, "R3 refused not stored");
        push(8, 3, 8'h83, 1'b1, "R3 join when full");
        chk("R5 window after fill", 64'({sseq(1), sseq(0)}), 64'({4'd6, 4'd5}));

        // R6 partial removal
        rm_mask = {4'b0000, 4'b0001};
        tick();
        rm_mask = '0;
        chk("R6 lane cleared", 64'(smask(0)), 64'b0100);
        chk("R6 slot1 untouched", 64'(smask(1)), 64'b0010);
        // R7 release on last lane
        rm_mask = {4'b0000, 4'b0100};
        tick();
        rm_mask = '0;
        chk("R7 window shift", 64'({sseq(1), sseq(0)}), 64'({4'd7, 4'd6}));
        query(5, 1'b1, "R8 drained");
        query(8, 1'b0, "R8 still held");
        push(9, 1, 8'h91, 1'b1, "R7 column reused");
        query(9, 1'b0, "R7 new group held");
        drain();
        chk("R7 all drained", 64'(win_valid), 64'd0);
        query(9, 1'b1, "R8 after drain");
        chk("R3 ready after drain", 64'(in_ready), 64'd1);

        // R5 wrap of sequence numbers
        push(14, 0, 1, 1'b1, "R5 wrap a");
        push(15, 0, 2, 1'b1, "R5 wrap b");
        push(0, 0, 3, 1'b1, "R5 wrap c");
        push(1, 0, 4, 1'b1, "R5 wrap d");
        chk("R5 wrap oldest", 64'({sseq(1), sseq(0)}), 64'({4'd15, 4'd14}));
        rm_mask = {4'b0001, 4'b0001};
        tick();
        rm_mask = '0;
        chk("R5 wrap next", 64'({sseq(1), sseq(0)}), 64'({4'd1, 4'd0}));
        drain();

        // R6 bits on an invalid slot are ignored
        push(3, 1, 8'h31, 1'b1, "R6 setup");
        push(3, 2, 8'h32, 1'b1, "R6 setup");
        chk("R5 single slot", 64'(win_valid), 64'b01);
        rm_mask = {4'b1111, 4'b0000};
        tick();
        rm_mask = '0;
        chk("R6 invalid slot ignored", 64'(smask(0)), 64'b0110);
        chk("R6 still valid", 64'(win_valid), 64'b01);
        drain();

        // R9 and R10 watchdog timing from group open
        do_reset();
        push(2, 0, 8'h20, 1'b1, "R9 open");
        for (int i = 0; i < 9; i++) tick();
        push(2, 1, 8'h21, 1'b1, "R10 late join");
        for (int i = 0; i < LIM - 11; i++) tick();
        chk("R9 quiet before limit", 64'(stall), 64'd0);
        tick();
        tick();
        tick();
        chk("R10 fires from open", 64'(stall), 64'd1);
        drain();
        tick();
        chk("R9 sticky", 64'(stall), 64'd1);

        do_reset();
        push(4, 0, 8'h40, 1'b1, "R9 open short");
        for (int i = 0; i < LIM - 5; i++) tick();
        drain();
        for (int i = 0; i < 2 * LIM; i++) tick();
        chk("R9 no stall when drained", 64'(stall), 64'd0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule